// File: doc/BRIEF.md
# Prioritized Power-State Trigger Controller

This block is the decision core of a power manager. It watches a set of trigger sources and chooses the one that wins. The sources are fault flags, on and off requests, two wake pins, two sleep-control pins and four software command bits. A trigger can win only if it is allowed in the present power state. The states are STANDBY, ACTIVE, MCU_ONLY, SUSPEND and SAFE. When a trigger wins, the block moves to that trigger's destination state. In the same step it raises a one-cycle start strobe and presents a sequence code that names the power sequence to run. The regulator sequencer that runs the sequence is outside this block. It reports completion with a one-cycle done pulse.

The code stays on the output until that done pulse arrives, and while it is held no ordinary trigger is taken. Three shutdown triggers are exempt from this wait: they take effect in the middle of a sequence. SAFE is terminal. Only reset leaves it, and reset enters STANDBY. Fault flags, requests and software bits are synchronous levels. The wake and sleep pins are asynchronous. They pass through a synchronizer, and the block acts on their edges. An edge that arrives while a sequence is running is remembered until the next evaluation.

Top module: `pwr_state_arbiter`

## Requirements
- R1: After reset the state output is STANDBY (code 0), seqCode is 0 and seqStart is low. The state codes are STANDBY=0, ACTIVE=1, MCU_ONLY=2, SUSPEND=3 and SAFE=4.
- R2: When several triggers are eligible, the one with the higher priority wins. Priority, highest first: immShutdown, mcuPwrErr, orderlyShutdown, offReq, the faults, socPwrErr, software bits 1 and 2, the ACTIVE wake sources, the MCU_ONLY wake sources, the sleep-pin combinations, software bit 0, software bit 3.
- R3: immShutdown, mcuPwrErr and orderlyShutdown move any state except SAFE to SAFE, with seqCode 1, 2 and 3 respectively. SAFE takes no trigger, and only reset leaves it.
- R4: The three shutdown triggers are taken even while a sequence is pending. Every other trigger waits for seqDone, and until then state and seqCode stay unchanged.
- R5: offReq moves to STANDBY with seqCode 4. A rising edge of swCmd[0] does the same, from ACTIVE or MCU_ONLY.
- R6: In ACTIVE, wdogErr or mcuMonErr reruns ACTIVE with seqCode 5, and socMonErr reruns ACTIVE with seqCode 6. In MCU_ONLY, wdogErr or mcuMonErr reruns MCU_ONLY with seqCode 7.
- R7: socPwrErr in ACTIVE moves to MCU_ONLY with seqCode 8. In any other state it is ignored.
- R8: onReq, a rising edge of wake1, or both sleep pins high moves to ACTIVE with seqCode 11. mcuOnReq or a rising edge of wake2 moves to MCU_ONLY with seqCode 12. A change of the sleep pins to sleep1 low and sleep2 high also moves to MCU_ONLY with seqCode 12, from ACTIVE, MCU_ONLY or SUSPEND but not from STANDBY.
- R9: A change of the sleep pins to both low, or to sleep1 high and sleep2 low, moves to SUSPEND with seqCode 13. This applies only from ACTIVE or MCU_ONLY.
- R10: In ACTIVE or MCU_ONLY, the level of swCmd[1] runs seqCode 9 and the level of swCmd[2] runs seqCode 10. A rising edge of swCmd[3] runs seqCode 14. None of these changes the state. In other states they are ignored.
- R11: A trigger that is not a rerun and whose destination is the present state is ignored: no seqStart and no change of seqCode.
- R12: seqStart is high for exactly the cycle in which a new seqCode is loaded. seqCode holds until seqDone and then returns to 0.
- R13: The wake and sleep pins pass through two synchronizer flops and are then edge-detected. An edge seen while a sequence is pending is kept and taken after seqDone. An edge that is not allowed in the state at evaluation time is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| immShutdown | input | 1 | Severe shutdown fault level |
| mcuPwrErr | input | 1 | MCU supply fault level |
| orderlyShutdown | input | 1 | Orderly shutdown request level |
| offReq | input | 1 | Off request level |
| wdogErr | input | 1 | Watchdog fault level |
| mcuMonErr | input | 1 | MCU error-monitor fault level |
| socMonErr | input | 1 | SoC error-monitor fault level |
| socPwrErr | input | 1 | SoC supply fault level |
| onReq | input | 1 | On request level |
| mcuOnReq | input | 1 | MCU-only on request level |
| wake1 | input | 1 | Asynchronous wake pin toward ACTIVE |
| wake2 | input | 1 | Asynchronous wake pin toward MCU_ONLY |
| sleep1 | input | 1 | Asynchronous sleep-control pin 1 |
| sleep2 | input | 1 | Asynchronous sleep-control pin 2 |
| swCmd | input | 4 | Software command bits |
| seqDone | input | 1 | Completion pulse from the sequencer |
| state | output | 3 | Present power state code |
| seqCode | output | 4 | Selected sequence, 0 when idle |
| seqStart | output | 1 | One-cycle strobe when seqCode is loaded |

## Verification
Single triggers are applied from each state to test the destination table and the reruns. Pairs of simultaneous triggers test the priority order. Triggers raised while a sequence is pending separate the shutdown triggers, which cut in, from queued triggers, which wait for seqDone. Sleep-pin patterns applied in STANDBY and in the operating states separate remembered edges from discarded ones. A repeat request for the present state confirms that a trigger with nothing to do produces no strobe.

// File: rtl/pwr_arb_pkg.sv
package pwr_arb_pkg;

  localparam int NUM_TRIG   = 22;
  localparam int TRIG_W     = $clog2(NUM_TRIG);
  localparam int SEQ_W      = 4;
  localparam int NUM_STATES = 5;
  localparam int NUM_PINS   = 4;
  localparam int SW_W       = 4;

  typedef enum logic [2:0] {
    PS_STANDBY = 3'd0,
    PS_ACTIVE  = 3'd1,
    PS_MCU     = 3'd2,
    PS_SUSPEND = 3'd3,
    PS_SAFE    = 3'd4
  } pwrState_e;

  // sequence codes
  localparam logic [SEQ_W-1:0] SQ_NONE      = 4'd0;
  localparam logic [SEQ_W-1:0] SQ_SAFE_HARD = 4'd1;
  localparam logic [SEQ_W-1:0] SQ_SAFE_NORM = 4'd2;
  localparam logic [SEQ_W-1:0] SQ_SAFE_SOFT = 4'd3;
  localparam logic [SEQ_W-1:0] SQ_STANDBY   = 4'd4;
  localparam logic [SEQ_W-1:0] SQ_ACT_WARM  = 4'd5;
  localparam logic [SEQ_W-1:0] SQ_SOC_FAULT = 4'd6;
  localparam logic [SEQ_W-1:0] SQ_MCU_WARM  = 4'd7;
  localparam logic [SEQ_W-1:0] SQ_SOC_DROP  = 4'd8;
  localparam logic [SEQ_W-1:0] SQ_SELFTEST  = 4'd9;
  localparam logic [SEQ_W-1:0] SQ_CRC_ON    = 4'd10;
  localparam logic [SEQ_W-1:0] SQ_ACTIVE    = 4'd11;
  localparam logic [SEQ_W-1:0] SQ_MCU       = 4'd12;
  localparam logic [SEQ_W-1:0] SQ_SUSPEND   = 4'd13;
  localparam logic [SEQ_W-1:0] SQ_UPD_PREP  = 4'd14;

  // source-state masks, bit index = state code
  localparam logic [NUM_STATES-1:0] SM_OPS  = 5'b01111;
  localparam logic [NUM_STATES-1:0] SM_ACT  = 5'b00010;
  localparam logic [NUM_STATES-1:0] SM_MCU  = 5'b00100;
  localparam logic [NUM_STATES-1:0] SM_RUN  = 5'b00110;
  localparam logic [NUM_STATES-1:0] SM_RUNS = 5'b01110;
  localparam logic [NUM_STATES-1:0] SM_RUNB = 5'b00111;

  // trigger slots that come from edges and are remembered
  localparam logic [NUM_TRIG-1:0] EVENT_MASK =
    (NUM_TRIG'(1) << 13) | (NUM_TRIG'(1) << 16) | (NUM_TRIG'(1) << 17) |
    (NUM_TRIG'(1) << 18) | (NUM_TRIG'(1) << 19) | (NUM_TRIG'(1) << 20) |
    (NUM_TRIG'(1) << 21);

  typedef struct packed {
    logic [NUM_STATES-1:0] srcMask;
    logic                  keep;
    pwrState_e             dst;
    logic                  reent;
    logic                  imm;
    logic [SEQ_W-1:0]      seq;
  } trigRule_t;

  typedef struct packed {
    logic immShutdown;
    logic mcuPwrErr;
    logic orderlyShutdown;
    logic offReq;
    logic wdogErr;
    logic mcuMonErr;
    logic socMonErr;
    logic socPwrErr;
    logic onReq;
    logic mcuOnReq;
  } trigLvl_t;

  typedef struct packed {
    logic evalNow;
    logic takeWin;
  } ctrlStrobe_t;

  function automatic trigRule_t mkRule(logic [NUM_STATES-1:0] src, pwrState_e dst,
                                       logic [SEQ_W-1:0] seq, logic imm,
                                       logic reent, logic keep);
    trigRule_t r;
    r.srcMask = src;
    r.dst     = dst;
    r.seq     = seq;
    r.imm     = imm;
    r.reent   = reent;
    r.keep    = keep;
    return r;
  endfunction

  // slot index = priority (0 highest)
  function automatic trigRule_t ruleOf(int k);
    case (k)
      0:  return mkRule(SM_OPS,  PS_SAFE,    SQ_SAFE_HARD, 1'b1, 1'b0, 1'b0);
      1:  return mkRule(SM_OPS,  PS_SAFE,    SQ_SAFE_NORM, 1'b1, 1'b0, 1'b0);
      2:  return mkRule(SM_OPS,  PS_SAFE,    SQ_SAFE_SOFT, 1'b1, 1'b0, 1'b0);
      3:  return mkRule(SM_OPS,  PS_STANDBY, SQ_STANDBY,   1'b0, 1'b0, 1'b0);
      4:  return mkRule(SM_ACT,  PS_ACTIVE,  SQ_ACT_WARM,  1'b0, 1'b1, 1'b0);
      5:  return mkRule(SM_ACT,  PS_ACTIVE,  SQ_ACT_WARM,  1'b0, 1'b1, 1'b0);
      6:  return mkRule(SM_ACT,  PS_ACTIVE,  SQ_SOC_FAULT, 1'b0, 1'b1, 1'b0);
      7:  return mkRule(SM_MCU,  PS_MCU,     SQ_MCU_WARM,  1'b0, 1'b1, 1'b0);
      8:  return mkRule(SM_MCU,  PS_MCU,     SQ_MCU_WARM,  1'b0, 1'b1, 1'b0);
      9:  return mkRule(SM_ACT,  PS_MCU,     SQ_SOC_DROP,  1'b0, 1'b0, 1'b0);
      10: return mkRule(SM_RUN,  PS_STANDBY, SQ_SELFTEST,  1'b0, 1'b1, 1'b1);
      11: return mkRule(SM_RUN,  PS_STANDBY, SQ_CRC_ON,    1'b0, 1'b1, 1'b1);
      12: return mkRule(SM_OPS,  PS_ACTIVE,  SQ_ACTIVE,    1'b0, 1'b0, 1'b0);
      13: return mkRule(SM_OPS,  PS_ACTIVE,  SQ_ACTIVE,    1'b0, 1'b0, 1'b0);
      14: return mkRule(SM_OPS,  PS_ACTIVE,  SQ_ACTIVE,    1'b0, 1'b0, 1'b0);
      15: return mkRule(SM_OPS,  PS_MCU,     SQ_MCU,       1'b0, 1'b0, 1'b0);
      16: return mkRule(SM_OPS,  PS_MCU,     SQ_MCU,       1'b0, 1'b0, 1'b0);
      17: return mkRule(SM_RUNS, PS_MCU,     SQ_MCU,       1'b0, 1'b0, 1'b0);
      18: return mkRule(SM_RUN,  PS_SUSPEND, SQ_SUSPEND,   1'b0, 1'b0, 1'b0);
      19: return mkRule(SM_RUN,  PS_SUSPEND, SQ_SUSPEND,   1'b0, 1'b0, 1'b0);
      20: return mkRule(SM_RUNB, PS_STANDBY, SQ_STANDBY,   1'b0, 1'b0, 1'b0);
      21: return mkRule(SM_RUN,  PS_STANDBY, SQ_UPD_PREP,  1'b0, 1'b0, 1'b1);
      default: return mkRule('0, PS_STANDBY, SQ_NONE, 1'b0, 1'b0, 1'b0);
    endcase
  endfunction

endpackage

// File: rtl/pwr_arb_datapath.sv
module pwr_arb_datapath
  import pwr_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  trigLvl_t             lvlIn,
  input  logic [NUM_PINS-1:0]  pinsIn,   // {sleep2, sleep1, wake2, wake1}
  input  logic [SW_W-1:0]      swCmd,
  input  pwrState_e            curState,
  input  ctrlStrobe_t          strobe,
  output logic                 winValid,
  output logic [TRIG_W-1:0]    winIdx,
  output logic                 immValid,
  output logic [TRIG_W-1:0]    immIdx
);

  logic [SYNC_STAGES-1:0][NUM_PINS-1:0] syncQ;
  logic [NUM_PINS-1:0] pinSync, pinPrev;
  logic [SW_W-1:0]     swPrev;
  logic [NUM_TRIG-1:0] lvlVec, evtVec, pend, live, elig, clrMask, winOneHot;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= '0;
      swPrev  <= '0;
    end else begin
      syncQ[0] <= pinsIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      pinPrev <= pinSync;
      swPrev  <= swCmd;
    end
  end

  assign pinSync = syncQ[SYNC_STAGES-1];

  logic [1:0] wakeRise;
  logic       sleepChg;
  logic [1:0] sw03Rise;
  assign wakeRise = pinSync[1:0] & ~pinPrev[1:0];
  assign sleepChg = (pinSync[3:2] != pinPrev[3:2]);
  assign sw03Rise = {swCmd[3] & ~swPrev[3], swCmd[0] & ~swPrev[0]};

  always_comb begin
    lvlVec     = '0;
    lvlVec[0]  = lvlIn.immShutdown;
    lvlVec[1]  = lvlIn.mcuPwrErr;
    lvlVec[2]  = lvlIn.orderlyShutdown;
    lvlVec[3]  = lvlIn.offReq;
    lvlVec[4]  = lvlIn.wdogErr;
    lvlVec[5]  = lvlIn.mcuMonErr;
    lvlVec[6]  = lvlIn.socMonErr;
    lvlVec[7]  = lvlIn.wdogErr;
    lvlVec[8]  = lvlIn.mcuMonErr;
    lvlVec[9]  = lvlIn.socPwrErr;
    lvlVec[10] = swCmd[1];
    lvlVec[11] = swCmd[2];
    lvlVec[12] = lvlIn.onReq;
    lvlVec[14] = pinSync[2] & pinSync[3];
    lvlVec[15] = lvlIn.mcuOnReq;
  end

  always_comb begin
    evtVec     = '0;
    evtVec[13] = wakeRise[0];
    evtVec[16] = wakeRise[1];
    evtVec[17] = sleepChg & ~pinSync[2] &  pinSync[3];
    evtVec[18] = sleepChg & ~pinSync[2] & ~pinSync[3];
    evtVec[19] = sleepChg &  pinSync[2] & ~pinSync[3];
    evtVec[20] = sw03Rise[0];
    evtVec[21] = sw03Rise[1];
  end

  assign live = lvlVec | evtVec | pend;

  // per-slot eligibility: allowed source state and a real change
  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_elig
    localparam trigRule_t RULE = ruleOf(k);
    assign elig[k] = live[k] && RULE.srcMask[curState] &&
                     (RULE.reent || RULE.keep || (RULE.dst != curState));
  end

  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    immValid = 1'b0;
    immIdx   = '0;
    for (int k = NUM_TRIG - 1; k >= 0; k--) begin
      if (elig[k]) begin
        winValid = 1'b1;
        winIdx   = TRIG_W'(k);
      end
      if (elig[k] && ruleOf(k).imm) begin
        immValid = 1'b1;
        immIdx   = TRIG_W'(k);
      end
    end
  end

  assign winOneHot = NUM_TRIG'(1) << winIdx;
  assign clrMask   = strobe.evalNow ?
                     (~elig | (strobe.takeWin ? winOneHot : '0)) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) pend <= '0;
    else       pend <= (pend | evtVec) & ~clrMask & EVENT_MASK;
  end

  // R8: the low/high sleep combination never wins in STANDBY
  a_r8_no_sleep_mcu_from_standby: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && curState == PS_STANDBY) |-> (winIdx != TRIG_W'(17)));

  // R10: software no-change requests only win in ACTIVE or MCU_ONLY
  a_r10_sw_src: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && (winIdx == TRIG_W'(10) || winIdx == TRIG_W'(11) || winIdx == TRIG_W'(21)))
      |-> (curState == PS_ACTIVE || curState == PS_MCU));

endmodule

// File: rtl/pwr_arb_control.sv
module pwr_arb_control
  import pwr_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              winValid,
  input  logic [TRIG_W-1:0] winIdx,
  input  logic              immValid,
  input  logic [TRIG_W-1:0] immIdx,
  input  logic              seqDone,
  output pwrState_e         curState,
  output logic [SEQ_W-1:0]  seqCode,
  output logic              seqStart,
  output ctrlStrobe_t       strobe
);

  logic              busy;
  logic              takeImm, go;
  logic [TRIG_W-1:0] pick;
  trigRule_t         rule;

  always_comb begin
    strobe.evalNow = !busy;
    strobe.takeWin = !busy && winValid;
    takeImm        = busy && immValid;
    go             = strobe.takeWin || takeImm;
    pick           = busy ? immIdx : winIdx;
    rule           = ruleOf(int'(pick));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= PS_STANDBY;
      seqCode  <= SQ_NONE;
      seqStart <= 1'b0;
      busy     <= 1'b0;
    end else begin
      seqStart <= go;
      if (go) begin
        if (!rule.keep) curState <= rule.dst;
        seqCode <= rule.seq;
        busy    <= 1'b1;
      end else if (seqDone) begin
        seqCode <= SQ_NONE;
        busy    <= 1'b0;
      end
    end
  end

  a_r3_safe_sticky: assert property (@(posedge clk) disable iff (!rstN)
    curState == PS_SAFE |=> curState == PS_SAFE);

  a_r3_safe_entry_code: assert property (@(posedge clk) disable iff (!rstN)
    curState != PS_SAFE |=> (curState != PS_SAFE ||
      seqCode == SQ_SAFE_HARD || seqCode == SQ_SAFE_NORM || seqCode == SQ_SAFE_SOFT));

  a_r4_wait_for_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !seqDone && !immValid) |=> ($stable(curState) && $stable(seqCode) && !seqStart));

  a_r9_suspend_source: assert property (@(posedge clk) disable iff (!rstN)
    curState != PS_SUSPEND |=> (curState != PS_SUSPEND ||
      $past(curState) == PS_ACTIVE || $past(curState) == PS_MCU));

  a_r12_clear_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && seqDone && !immValid) |=> (seqCode == SQ_NONE && !seqStart));

endmodule

// File: rtl/pwr_state_arbiter.sv
module pwr_state_arbiter
  import pwr_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        immShutdown,
  input  logic        mcuPwrErr,
  input  logic        orderlyShutdown,
  input  logic        offReq,
  input  logic        wdogErr,
  input  logic        mcuMonErr,
  input  logic        socMonErr,
  input  logic        socPwrErr,
  input  logic        onReq,
  input  logic        mcuOnReq,
  input  logic        wake1,
  input  logic        wake2,
  input  logic        sleep1,
  input  logic        sleep2,
  input  logic [3:0]  swCmd,
  input  logic        seqDone,
  output logic [2:0]  state,
  output logic [3:0]  seqCode,
  output logic        seqStart
);

  trigLvl_t          lvl;
  ctrlStrobe_t       strobe;
  pwrState_e         curState;
  logic              winValid, immValid;
  logic [TRIG_W-1:0] winIdx, immIdx;

  assign lvl = '{immShutdown: immShutdown, mcuPwrErr: mcuPwrErr,
                 orderlyShutdown: orderlyShutdown, offReq: offReq,
                 wdogErr: wdogErr, mcuMonErr: mcuMonErr, socMonErr: socMonErr,
                 socPwrErr: socPwrErr, onReq: onReq, mcuOnReq: mcuOnReq};

  pwr_arb_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lvlIn    (lvl),
    .pinsIn   ({sleep2, sleep1, wake2, wake1}),
    .swCmd    (swCmd),
    .curState (curState),
    .strobe   (strobe),
    .winValid (winValid),
    .winIdx   (winIdx),
    .immValid (immValid),
    .immIdx   (immIdx)
  );

  pwr_arb_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .winValid (winValid),
    .winIdx   (winIdx),
    .immValid (immValid),
    .immIdx   (immIdx),
    .seqDone  (seqDone),
    .curState (curState),
    .seqCode  (seqCode),
    .seqStart (seqStart),
    .strobe   (strobe)
  );

  assign state = curState;

endmodule

// File: tb/pwr_state_arbiter_bench.sv
`timescale 1ns/1ps
module pwr_state_arbiter_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic immShutdown = 0, mcuPwrErr = 0, orderlyShutdown = 0, offReq = 0;
  logic wdogErr = 0, mcuMonErr = 0, socMonErr = 0, socPwrErr = 0;
  logic onReq = 0, mcuOnReq = 0, wake1 = 0, wake2 = 0, sleep1 = 0, sleep2 = 0;
  logic [3:0] swCmd = '0;
  logic seqDone = 0;
  logic [2:0] state;
  logic [3:0] seqCode;
  logic seqStart;

  int checks = 0, fails = 0, startCnt = 0;
  logic [3:0] lastCode = '0;

  localparam logic [2:0] SB = 3'd0, AC = 3'd1, MC = 3'd2, SU = 3'd3, SF = 3'd4;

  always #2.5 clk = ~clk;

  pwr_state_arbiter u_pwr_state_arbiter (
    .clk(clk), .rstN(rstN), .immShutdown(immShutdown), .mcuPwrErr(mcuPwrErr),
    .orderlyShutdown(orderlyShutdown), .offReq(offReq), .wdogErr(wdogErr),
    .mcuMonErr(mcuMonErr), .socMonErr(socMonErr), .socPwrErr(socPwrErr),
    .onReq(onReq), .mcuOnReq(mcuOnReq), .wake1(wake1), .wake2(wake2),
    .sleep1(sleep1), .sleep2(sleep2), .swCmd(swCmd), .seqDone(seqDone),
    .state(state), .seqCode(seqCode), .seqStart(seqStart));

  always @(posedge clk) begin
    #1;
    if (rstN && seqStart) begin
      startCnt++;
      lastCode = seqCode;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect3(string req, int st, int code, int cnt);
    chk(req, "state", state, st);
    chk(req, "seqCode", seqCode, code);
    chk(req, "start count", startCnt, cnt);
  endtask

  task automatic finishSeq();
    @(negedge clk) seqDone = 1;
    @(negedge clk) seqDone = 0;
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 0;
    tick(3);
    startCnt = 0;
    rstN = 1;
    tick(1);
  endtask

  task automatic t_reset();
    doReset();
    expect3("R1", SB, 0, 0);
    chk("R1", "seqStart", seqStart, 0);
  endtask

  task automatic t_wake_hold();
    @(negedge clk) onReq = 1;
    @(negedge clk) onReq = 0;
    expect3("R8", AC, 11, 1);
    tick(2);
    chk("R12", "held code", seqCode, 11);
    finishSeq();
    tick(1);
    chk("R12", "code after done", seqCode, 0);
    @(negedge clk) onReq = 1;
    @(negedge clk) onReq = 0;
    tick(1);
    expect3("R11", AC, 0, 1);
  endtask

  task automatic t_queue();
    @(negedge clk) mcuOnReq = 1;
    @(negedge clk) mcuOnReq = 0;
    expect3("R8", MC, 12, 2);
    wdogErr = 1;
    tick(3);
    expect3("R4", MC, 12, 2);
    finishSeq();
    tick(1);
    wdogErr = 0;
    expect3("R6", MC, 7, 3);
    finishSeq();
  endtask

  task automatic t_active_faults();
    @(negedge clk) onReq = 1;
    @(negedge clk) onReq = 0;
    expect3("R8", AC, 11, 4);
    finishSeq();
    @(negedge clk) socMonErr = 1;
    @(negedge clk) socMonErr = 0;
    expect3("R6", AC, 6, 5);
    finishSeq();
    @(negedge clk) wdogErr = 1;
    @(negedge clk) wdogErr = 0;
    expect3("R6", AC, 5, 6);
    finishSeq();
    @(negedge clk) socPwrErr = 1;
    @(negedge clk) socPwrErr = 0;
    expect3("R7", MC, 8, 7);
    finishSeq();
    @(negedge clk) socPwrErr = 1;
    @(negedge clk) socPwrErr = 0;
    tick(1);
    expect3("R7", MC, 0, 7);
  endtask

  task automatic t_software();
    @(negedge clk) swCmd[1] = 1;
    @(negedge clk) swCmd[1] = 0;
    expect3("R10", MC, 9, 8);
    finishSeq();
    @(negedge clk) swCmd[3] = 1;
    @(negedge clk) swCmd[3] = 0;
    expect3("R10", MC, 14, 9);
    finishSeq();
  endtask

  task automatic t_sleep();
    @(negedge clk) begin sleep1 = 1; sleep2 = 0; end
    tick(5);
    expect3("R9", SU, 13, 10);
    finishSeq();
    @(negedge clk) begin sleep1 = 0; sleep2 = 1; end
    tick(5);
    expect3("R8", MC, 12, 11);
    finishSeq();
    @(negedge clk) sleep1 = 1;
    tick(5);
    expect3("R8", AC, 11, 12);
    finishSeq();
    @(negedge clk) begin sleep1 = 0; sleep2 = 0; end
    tick(5);
    expect3("R9", SU, 13, 13);
    finishSeq();
    @(negedge clk) offReq = 1;
    @(negedge clk) offReq = 0;
    expect3("R5", SB, 4, 14);
    finishSeq();
  endtask

  task automatic t_standby_ignore();
    @(negedge clk) swCmd[1] = 1;
    @(negedge clk) swCmd[1] = 0;
    tick(1);
    expect3("R10", SB, 0, 14);
    @(negedge clk) sleep2 = 1;
    tick(5);
    expect3("R8", SB, 0, 14);
    @(negedge clk) onReq = 1;
    @(negedge clk) onReq = 0;
    expect3("R8", AC, 11, 15);
    finishSeq();
    tick(3);
    expect3("R13", AC, 0, 15);
    @(negedge clk) sleep2 = 0;
    tick(5);
    expect3("R9", SU, 13, 16);
    finishSeq();
    @(negedge clk) swCmd[0] = 1;
    @(negedge clk) swCmd[0] = 0;
    tick(1);
    expect3("R5", SU, 0, 16);
    @(negedge clk) offReq = 1;
    @(negedge clk) offReq = 0;
    expect3("R5", SB, 4, 17);
    finishSeq();
  endtask

  task automatic t_pending_edge();
    @(negedge clk) mcuOnReq = 1;
    @(negedge clk) mcuOnReq = 0;
    expect3("R8", MC, 12, 18);
    wake1 = 1;
    tick(6);
    expect3("R13", MC, 12, 18);
    finishSeq();
    tick(1);
    expect3("R13", AC, 11, 19);
    wake1 = 0;
  endtask

  task automatic t_immediate();
    @(negedge clk) orderlyShutdown = 1;
    @(negedge clk) orderlyShutdown = 0;
    expect3("R4", SF, 3, 20);
    finishSeq();
    @(negedge clk) begin onReq = 1; offReq = 1; end
    @(negedge clk) begin onReq = 0; offReq = 0; end
    tick(2);
    expect3("R3", SF, 0, 20);
    doReset();
    expect3("R3", SB, 0, 0);
  endtask

  task automatic t_priority();
    @(negedge clk) onReq = 1;
    @(negedge clk) onReq = 0;
    finishSeq();
    @(negedge clk) begin immShutdown = 1; mcuPwrErr = 1; end
    @(negedge clk) begin immShutdown = 0; mcuPwrErr = 0; end
    expect3("R2", SF, 1, 2);
    doReset();
    @(negedge clk) onReq = 1;
    @(negedge clk) onReq = 0;
    finishSeq();
    @(negedge clk) begin offReq = 1; mcuOnReq = 1; end
    @(negedge clk) begin offReq = 0; mcuOnReq = 0; end
    expect3("R2", SB, 4, 2);
    finishSeq();
    @(negedge clk) wake2 = 1;
    tick(5);
    expect3("R8", MC, 12, 3);
    wake2 = 0;
    finishSeq();
    doReset();
    @(negedge clk) mcuPwrErr = 1;
    @(negedge clk) mcuPwrErr = 0;
    expect3("R3", SF, 2, 1);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_wake_hold();
    t_queue();
    t_active_faults();
    t_software();
    t_sleep();
    t_standby_ignore();
    t_pending_edge();
    t_immediate();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule